// File: doc/BRIEF.md
# Multiword Two's-Complement ALU with Result File and Range Flag

This block is a word-serial arithmetic and logic unit. Each clock edge captures a 5-bit opcode, two operand words, an external carry-in, a 3-bit result-file code and a first-word marker. The selected operation then runs during the cycle after that edge. The operations are add and subtract with a choice of carry source, single-bit right shifts, bitwise logic, mask constants, flag-mode selection and a clear. A one-bit carry register takes the carry-out of every operation. Arithmetic wider than one word is processed least significant word first over successive cycles, with the carry passed from one word to the next.

Results go into a file of two words, called left and right. The result-file code chooses which of them load at the end of the cycle and which one drives the output during the cycle. One code skips the file and sends the fresh result straight to the output.

A single range flag reports one of four conditions on the current result. Three of them guard against the word running out of range: signed overflow, one bit of headroom left, and two bits of headroom left. The fourth is a zero test that can span a multiword result. Which condition the flag reports is set by an instruction.

Top module: `wide_alu_core`

## Requirements
- R1: The opcode, operands, carry-in, result-file code and first-word marker are taken on a rising edge. The operation's result, carry-out and flag appear during the cycle that follows, and any result-file load happens on the next rising edge.
- R2: These opcodes use the adder. 0x01–0x03 give NOT A. 0x08–0x09 give A+B. 0x0A–0x0C give A+NOT B. 0x0D–0x0F give NOT A+B. The carry-in added at the LSB is 1 for 0x01, 0x0A and 0x0D. It is the external carry-in for 0x02, 0x08, 0x0B and 0x0E, and the carry register for 0x03, 0x09, 0x0C and 0x0F. The carry-out output is the carry out of the word MSB.
- R3: The carry-out of each executed operation is stored in the carry register on the next edge, so a two-word sum can be chained from one cycle to the next.
- R4: Opcodes 0x04–0x07 shift A right by one bit and drop its LSB. The new MSB is filled from a different source for each opcode: 0x04 copies the old MSB of A, 0x05 takes bit 0 of the left word, 0x06 takes bit 0 of the right word, and 0x07 takes bit 0 of B.
- R5: Opcodes 0x10 to 0x17 are, in order: A AND B, A AND NOT B, NOT A AND B, A OR B, NOT A OR B, A XOR B, A, and NOT A. Every opcode from 0x10 up gives carry-out 0.
- R6: Opcodes 0x1C, 0x1D, 0x1E and 0x1F give the constants 0x0001, 0x00FF, 0x000F and 0x5555.
- R7: Opcodes 0x18 to 0x1B set the flag condition. 0x18 selects overflow, 0x19 one bit of headroom, 0x1A two bits of headroom, and 0x1B zero. While one of them executes the result is zero, and its own flag is evaluated under the mode it selects, so 0x1B raises the flag during its own execution.
- R8: Overflow mode flags carry-into-MSB XOR carry-out-of-MSB. The one-bit headroom mode flags a result whose top two bits differ. The two-bit headroom mode flags a result whose top three bits are not all equal.
- R9: Zero mode flags a zero result only if every result since the last cycle executed with the first-word marker set has also been zero. A cycle with the marker set starts a new chain.
- R10: Opcode 0x00 clears both file words, the carry register and the captured operands, which makes the next instruction see A=B=0. It also puts the flag back in overflow mode.
- R11: Result-file codes, as load/output: 0 left/right, 1 right/left, 2 left/left, 3 right/right, 4 both/left, 5 none/right, 6 none/left, 7 none/fresh result. The file output shows the word's value from before any load in that cycle.
- R12: Reset behaves like an executing clear. The output is zero, the carry register is zero and the flag is in overflow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | ALU opcode |
| rf_i | input | 3 | Result-file code |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| cin_i | input | 1 | External carry-in |
| first_i | input | 1 | Marks the first word of a multiword zero test |
| q_o | output | W | Result-file output |
| cout_o | output | 1 | Carry out of the word MSB |
| flag_o | output | 1 | Range flag under the selected condition |

## Verification
The bench builds the block with its default word width of 16. At that width, edge cases such as 0x7FFF+1 and the negation of 0x8000 show the overflow rule exactly at the sign boundary. At the same width the mask constants can be compared against their literal values, and the headroom modes can be driven with results whose top bits sit just inside or just outside each limit. Two-word chains run through the registered carry and through the zero chain, and a clear in the middle of a sequence shows what it wipes.

// File: rtl/wa_pkg.sv
package wa_pkg;

   typedef enum logic [4:0] {
      OP_CLR  = 5'h00, OP_NA1  = 5'h01, OP_NACI = 5'h02, OP_NACO = 5'h03,
      OP_SHS  = 5'h04, OP_SHL  = 5'h05, OP_SHR  = 5'h06, OP_SHB  = 5'h07,
      OP_ABCI = 5'h08, OP_ABCO = 5'h09, OP_AN1  = 5'h0A, OP_ANCI = 5'h0B,
      OP_ANCO = 5'h0C, OP_NB1  = 5'h0D, OP_NBCI = 5'h0E, OP_NBCO = 5'h0F,
      OP_AND  = 5'h10, OP_ANDN = 5'h11, OP_NAB  = 5'h12, OP_OR   = 5'h13,
      OP_NAOR = 5'h14, OP_XOR  = 5'h15, OP_PASS = 5'h16, OP_INV  = 5'h17,
      OP_FOVF = 5'h18, OP_FNR2 = 5'h19, OP_FNR4 = 5'h1A, OP_FZER = 5'h1B,
      OP_K1   = 5'h1C, OP_K8   = 5'h1D, OP_K4   = 5'h1E, OP_KALT = 5'h1F
   } alu_op_e;

   typedef enum logic [1:0] {FM_OVF, FM_NEAR2, FM_NEAR4, FM_ZERO} flag_mode_e;

   typedef enum logic [1:0] {OS_LEFT, OS_RIGHT, OS_FRESH} out_sel_e;

   typedef struct packed {
      logic     ld_l;
      logic     ld_r;
      out_sel_e sel;
   } rf_ctl_t;

   function automatic rf_ctl_t rf_decode(input logic [2:0] code);
      rf_ctl_t c;
      case (code)
         3'd0:    c = '{ld_l: 1'b1, ld_r: 1'b0, sel: OS_RIGHT};
         3'd1:    c = '{ld_l: 1'b0, ld_r: 1'b1, sel: OS_LEFT};
         3'd2:    c = '{ld_l: 1'b1, ld_r: 1'b0, sel: OS_LEFT};
         3'd3:    c = '{ld_l: 1'b0, ld_r: 1'b1, sel: OS_RIGHT};
         3'd4:    c = '{ld_l: 1'b1, ld_r: 1'b1, sel: OS_LEFT};
         3'd5:    c = '{ld_l: 1'b0, ld_r: 1'b0, sel: OS_RIGHT};
         3'd6:    c = '{ld_l: 1'b0, ld_r: 1'b0, sel: OS_LEFT};
         default: c = '{ld_l: 1'b0, ld_r: 1'b0, sel: OS_FRESH};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/wa_arith.sv
module wa_arith
   import wa_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           cin_ext,
   input  logic           cin_reg,
   input  logic           lsb_l,
   input  logic           lsb_r,
   output logic [W-1:0]   res,
   output logic           cout,
   output logic           ovf
);
   localparam int KB = (W < 8) ? W : 8;

   function automatic logic [W-1:0] alt_pattern();
      logic [W-1:0] v;
      for (int i = 0; i < W; i++) v[i] = ~i[0];
      return v;
   endfunction

   localparam logic [W-1:0] K_ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] K_BYTE = {{(W-KB){1'b0}}, {KB{1'b1}}};
   localparam logic [W-1:0] K_NIB  = {{(W-4){1'b0}}, 4'hF};
   localparam logic [W-1:0] K_ALT  = alt_pattern();

   logic [W-1:0] x, y, other;
   logic         c, use_add;
   logic [W-1:0] sum_lo;
   logic         c_msb;
   logic [1:0]   top;

   always_comb begin
      x = a; y = '0; c = 1'b0; use_add = 1'b1; other = '0;
      case (op)
         OP_NA1:  begin x = ~a; c = 1'b1;    end
         OP_NACI: begin x = ~a; c = cin_ext; end
         OP_NACO: begin x = ~a; c = cin_reg; end
         OP_ABCI: begin y = b;  c = cin_ext; end
         OP_ABCO: begin y = b;  c = cin_reg; end
         OP_AN1:  begin y = ~b; c = 1'b1;    end
         OP_ANCI: begin y = ~b; c = cin_ext; end
         OP_ANCO: begin y = ~b; c = cin_reg; end
         OP_NB1:  begin x = ~a; y = b; c = 1'b1;    end
         OP_NBCI: begin x = ~a; y = b; c = cin_ext; end
         OP_NBCO: begin x = ~a; y = b; c = cin_reg; end
         default: begin
            use_add = 1'b0;
            case (op)
               OP_SHS:  other = {a[W-1], a[W-1:1]};
               OP_SHL:  other = {lsb_l,  a[W-1:1]};
               OP_SHR:  other = {lsb_r,  a[W-1:1]};
               OP_SHB:  other = {b[0],   a[W-1:1]};
               OP_AND:  other = a & b;
               OP_ANDN: other = a & ~b;
               OP_NAB:  other = ~a & b;
               OP_OR:   other = a | b;
               OP_NAOR: other = ~a | b;
               OP_XOR:  other = a ^ b;
               OP_PASS: other = a;
               OP_INV:  other = ~a;
               OP_K1:   other = K_ONE;
               OP_K8:   other = K_BYTE;
               OP_K4:   other = K_NIB;
               OP_KALT: other = K_ALT;
               default: other = '0;
            endcase
         end
      endcase
   end

   // Adder split at the MSB so the carry into the sign bit is visible.
   always_comb begin
      sum_lo = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, c};
      c_msb  = sum_lo[W-1];
      top    = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, c_msb};
      res    = use_add ? {top[0], sum_lo[W-2:0]} : other;
      cout   = use_add & top[1];
      ovf    = use_add & (c_msb ^ top[1]);
   end

endmodule

// File: rtl/wa_flag.sv
module wa_flag
   import wa_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  alu_op_e      op,
   input  logic         first_i,
   input  logic [W-1:0] res_i,
   input  logic         ovf_i,
   output logic         flag_o
);
   flag_mode_e mode_q, eff;
   logic       zacc_q, is_set, zero_now, zero_ch;

   assign is_set   = (op[4:2] == 3'b110);
   assign eff      = is_set ? flag_mode_e'(op[1:0]) : mode_q;
   assign zero_now = (res_i == '0);
   assign zero_ch  = zero_now & (first_i | is_set | zacc_q);

   always_comb begin
      case (eff)
         FM_OVF:   flag_o = ovf_i;
         FM_NEAR2: flag_o = res_i[W-1] ^ res_i[W-2];
         FM_NEAR4: flag_o = ~((res_i[W-1:W-3] == 3'b000) | (res_i[W-1:W-3] == 3'b111));
         default:  flag_o = zero_ch;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= FM_OVF;
         zacc_q <= 1'b0;
      end else begin
         zacc_q <= zero_ch;
         if (op == OP_CLR)  mode_q <= FM_OVF;
         else if (is_set)   mode_q <= flag_mode_e'(op[1:0]);
      end
   end

   // R7: selecting the zero condition raises the flag in the same cycle
   assert_zero_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FZER) |-> flag_o);

   // R7: a mode-select instruction yields a zero result from the datapath
   assert_forced_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_set |-> (res_i == '0));

   // R9: a non-zero word breaks the chain for the following continuation word
   assert_chain_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eff == FM_ZERO && res_i != '0) |=> (first_i || is_set || !flag_o));

endmodule

// File: rtl/wa_regfile.sv
module wa_regfile
   import wa_pkg::*;
#(
   parameter int W = 16,
   parameter int NREG = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [2:0]   code,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         lsb_l,
   output logic         lsb_r
);
   rf_ctl_t      ctl;
   logic [NREG-1:0] ld;
   logic [W-1:0] word_q [NREG];

   assign ctl = rf_decode(code);
   assign ld  = {ctl.ld_r, ctl.ld_l};

   for (genvar i = 0; i < NREG; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      word_q[i] <= '0;
         else if (clr)    word_q[i] <= '0;
         else if (ld[i])  word_q[i] <= din;
      end

      // R11: a word not named by the code keeps its value
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!ld[i] && !clr) |=> $stable(word_q[i]));
   end

   always_comb begin
      case (ctl.sel)
         OS_LEFT:  q = word_q[0];
         OS_RIGHT: q = word_q[1];
         default:  q = din;
      endcase
   end

   assign lsb_l = word_q[0][0];
   assign lsb_r = word_q[1][0];

endmodule

// File: rtl/wide_alu_core.sv
module wide_alu_core
   import wa_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [4:0]   op_i,
   input  logic [2:0]   rf_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         first_i,
   output logic [W-1:0] q_o,
   output logic         cout_o,
   output logic         flag_o
);
   if (W < 8) begin : g_bad_width
      $error("wide_alu_core: W must be at least 8");
   end

   alu_op_e      op_q;
   logic [2:0]   rf_q;
   logic [W-1:0] a_q, b_q, res;
   logic         ci_q, first_q, carry_q, cout, ovf, clr, lsb_l, lsb_r;

   assign clr = (op_q == OP_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_CLR;
         rf_q    <= '0;
         a_q     <= '0;
         b_q     <= '0;
         ci_q    <= 1'b0;
         first_q <= 1'b0;
         carry_q <= 1'b0;
      end else begin
         op_q    <= alu_op_e'(op_i);
         rf_q    <= rf_i;
         ci_q    <= cin_i;
         first_q <= first_i;
         if (clr) begin
            a_q     <= '0;
            b_q     <= '0;
            carry_q <= 1'b0;
         end else begin
            a_q     <= a_i;
            b_q     <= b_i;
            carry_q <= cout;
         end
      end
   end

   wa_arith #(.W(W)) u_arith (
      .op(op_q), .a(a_q), .b(b_q), .cin_ext(ci_q), .cin_reg(carry_q),
      .lsb_l(lsb_l), .lsb_r(lsb_r), .res(res), .cout(cout), .ovf(ovf)
   );

   wa_flag #(.W(W)) u_flag (
      .clk(clk), .rst_n(rst_n), .op(op_q), .first_i(first_q),
      .res_i(res), .ovf_i(ovf), .flag_o(flag_o)
   );

   wa_regfile #(.W(W), .NREG(2)) u_rf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .code(rf_q), .din(res),
      .q(q_o), .lsb_l(lsb_l), .lsb_r(lsb_r)
   );

   assign cout_o = cout;

   // R10: after a clear, any file word selected for output reads zero
   assert_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rf_q == 3'd7 || q_o == '0));

   // R3: with zero operands, the chained add returns the stored carry
   assert_carry_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_ABCO && a_q == '0 && b_q == '0) |-> (res == {{(W-1){1'b0}}, carry_q}));

   // R5: operations outside the adder produce no carry-out
   assert_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_q[4] |-> !cout_o);

endmodule

// File: tb/sim_wide_alu_core.sv
module sim_wide_alu_core;
   localparam int PER = 10;
   localparam int NV  = 44;

   typedef struct packed {
      logic [4:0]  op;
      logic [15:0] a;
      logic [15:0] b;
      logic        ci;
      logic        first;
      logic [15:0] q;
      logic        co;
      logic        fl;
      logic [3:0]  rq;
   } vec_t;

   // All table steps use result-file code 7 (fresh result on the output).
   localparam vec_t TBL [NV] = '{
      {5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd12}, // R12 follow-up of reset
      {5'h08, 16'h1234, 16'h1111, 1'b0, 1'b1, 16'h2345, 1'b0, 1'b0, 4'd1},  // R1 R2
      {5'h08, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1, 4'd8},  // R8 overflow
      {5'h08, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b0, 4'd2},
      {5'h09, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b0, 4'd3},  // R3
      {5'h0A, 16'h0005, 16'h0003, 1'b0, 1'b1, 16'h0002, 1'b1, 1'b0, 4'd2},
      {5'h0D, 16'h0005, 16'h0003, 1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0, 4'd2},
      {5'h01, 16'h0001, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 4'd2},
      {5'h01, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd2},
      {5'h03, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd3},
      {5'h0C, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd3},
      {5'h0B, 16'h0000, 16'h0001, 1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0, 4'd2},
      {5'h0E, 16'h0001, 16'h0001, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd2},
      {5'h0F, 16'h0000, 16'h0005, 1'b0, 1'b1, 16'h0005, 1'b1, 1'b0, 4'd3},
      {5'h02, 16'h8000, 16'h0000, 1'b0, 1'b1, 16'h7FFF, 1'b0, 1'b0, 4'd2},
      {5'h01, 16'h8000, 16'h0000, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b1, 4'd8},  // R8 negate min
      {5'h10, 16'hF0F0, 16'hFF00, 1'b0, 1'b1, 16'hF000, 1'b0, 1'b0, 4'd5},  // R5
      {5'h11, 16'hF0F0, 16'hFF00, 1'b0, 1'b1, 16'h00F0, 1'b0, 1'b0, 4'd5},
      {5'h12, 16'hF0F0, 16'hFF00, 1'b0, 1'b1, 16'h0F00, 1'b0, 1'b0, 4'd5},
      {5'h13, 16'hF0F0, 16'h0F00, 1'b0, 1'b1, 16'hFFF0, 1'b0, 1'b0, 4'd5},
      {5'h14, 16'hF0F0, 16'h0003, 1'b0, 1'b1, 16'h0F0F, 1'b0, 1'b0, 4'd5},
      {5'h15, 16'hAAAA, 16'hFFFF, 1'b0, 1'b1, 16'h5555, 1'b0, 1'b0, 4'd5},
      {5'h16, 16'h1234, 16'h0000, 1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 4'd5},
      {5'h17, 16'h1234, 16'h0000, 1'b0, 1'b1, 16'hEDCB, 1'b0, 1'b0, 4'd5},
      {5'h1C, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b0, 4'd6},  // R6
      {5'h1D, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'h00FF, 1'b0, 1'b0, 4'd6},
      {5'h1E, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'h000F, 1'b0, 1'b0, 4'd6},
      {5'h1F, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'h5555, 1'b0, 1'b0, 4'd6},
      {5'h04, 16'h8002, 16'h0000, 1'b0, 1'b1, 16'hC001, 1'b0, 1'b0, 4'd4},  // R4
      {5'h04, 16'h4002, 16'h0000, 1'b0, 1'b1, 16'h2001, 1'b0, 1'b0, 4'd4},
      {5'h07, 16'h0002, 16'h0001, 1'b0, 1'b1, 16'h8001, 1'b0, 1'b0, 4'd4},
      {5'h19, 16'h1234, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7
      {5'h16, 16'h4000, 16'h0000, 1'b0, 1'b1, 16'h4000, 1'b0, 1'b1, 4'd8},  // R8 near 2
      {5'h16, 16'h2000, 16'h0000, 1'b0, 1'b1, 16'h2000, 1'b0, 1'b0, 4'd8},
      {5'h1A, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd7},
      {5'h16, 16'h2000, 16'h0000, 1'b0, 1'b1, 16'h2000, 1'b0, 1'b1, 4'd8},  // R8 near 4
      {5'h16, 16'hE000, 16'h0000, 1'b0, 1'b1, 16'hE000, 1'b0, 1'b0, 4'd8},
      {5'h1B, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 4'd7},
      {5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 4'd9},  // R9 chain
      {5'h16, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd9},
      {5'h16, 16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0, 4'd9},
      {5'h16, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd9},
      {5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 4'd9},
      {5'h18, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_i = '0;
   logic [2:0]  rf_i = '0;
   logic [15:0] a_i = '0, b_i = '0;
   logic        cin_i = 1'b0, first_i = 1'b0;
   logic [15:0] q_o;
   logic        cout_o, flag_o;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   wide_alu_core #(.W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .rf_i(rf_i), .a_i(a_i), .b_i(b_i),
      .cin_i(cin_i), .first_i(first_i), .q_o(q_o), .cout_o(cout_o), .flag_o(flag_o)
   );

   always #(PER/2) clk = ~clk;

   task automatic compare(input logic [15:0] eq, input logic eco, input logic efl,
                          input string tag);
      checks++;
      if (q_o !== eq || cout_o !== eco || flag_o !== efl) begin
         fails++;
         $display("FAIL %s: q=%h cout=%b flag=%b, expected q=%h cout=%b flag=%b",
                  tag, q_o, cout_o, flag_o, eq, eco, efl);
      end
   endtask

   // Drive at a falling edge, let the rising edge capture, check at the next falling edge.
   task automatic step(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic first, input logic [2:0] rf,
                       input logic [15:0] eq, input logic eco, input logic efl,
                       input string tag);
      op_i = op; a_i = a; b_i = b; cin_i = ci; first_i = first; rf_i = rf;
      @(posedge clk);
      #(PER/2);
      compare(eq, eco, efl, tag);
   endtask

   initial begin
      #(PER * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #(PER/2);
      rst_n = 1'b1;
      #1;
      compare(16'h0000, 1'b0, 1'b0, "R12");   // reset state

      for (int i = 0; i < NV; i++)
         step(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].ci, TBL[i].first, 3'd7,
              TBL[i].q, TBL[i].co, TBL[i].fl, $sformatf("R%0d", TBL[i].rq));

      // R11 result-file codes
      step(5'h00, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b0, 1'b0, "R10");
      step(5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b0, 1'b0, "R10");
      step(5'h16, 16'h1111, 16'h0000, 1'b0, 1'b1, 3'd2, 16'h0000, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h2222, 16'h0000, 1'b0, 1'b1, 3'd3, 16'h0000, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h3333, 16'h0000, 1'b0, 1'b1, 3'd5, 16'h2222, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h4444, 16'h0000, 1'b0, 1'b1, 3'd6, 16'h1111, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h5555, 16'h0000, 1'b0, 1'b1, 3'd0, 16'h2222, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h6666, 16'h0000, 1'b0, 1'b1, 3'd1, 16'h5555, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h7777, 16'h0000, 1'b0, 1'b1, 3'd4, 16'h5555, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd5, 16'h7777, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd6, 16'h7777, 1'b0, 1'b0, "R11");
      // R4 MSB taken from a file word: left=0001, right=0000
      step(5'h16, 16'h0001, 16'h0000, 1'b0, 1'b1, 3'd2, 16'h7777, 1'b0, 1'b0, "R11");
      step(5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd3, 16'h7777, 1'b0, 1'b0, "R11");
      step(5'h05, 16'h0004, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h8002, 1'b0, 1'b0, "R4");
      step(5'h06, 16'h0004, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0002, 1'b0, 1'b0, "R4");
      // R3 two-word add 0x0001FFFF + 0x00000001
      step(5'h08, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b1, 1'b0, "R3");
      step(5'h09, 16'h0001, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0002, 1'b0, 1'b0, "R3");
      // R10 clear wipes carry, mode, file words and the next operands
      step(5'h19, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b0, 1'b0, "R10");
      step(5'h08, 16'hFFFF, 16'h0001, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b1, 1'b0, "R10");
      step(5'h00, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b0, 1'b0, "R10");
      step(5'h09, 16'h4000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h0000, 1'b0, 1'b0, "R10");
      step(5'h16, 16'h4000, 16'h0000, 1'b0, 1'b1, 3'd7, 16'h4000, 1'b0, 1'b0, "R10");
      step(5'h16, 16'h0000, 16'h0000, 1'b0, 1'b1, 3'd6, 16'h0000, 1'b0, 1'b0, "R10");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule